// File: doc/BRIEF.md
# Translation Table Pointer Generator

This block forms the two memory pointers that miss-handling software uses to find candidate entries in its in-memory translation tables, one for the small page-size class (class A) and one for the large page-size class (class B). It takes the captured tag-access word (faulting virtual page plus context) and four configuration words: a table base and a table-shape word for context zero, and the same pair for all nonzero contexts. The class A and class B bases are separate words. The shape word is shared by the two classes.

The context field picks the register set. The index comes from the tag-access word, shifted right by an amount set by the page size, masked to the table size, and OR-ed into the table base. A class B table may be split. When it is, a single extra bit marks the upper half.

The pointer logic is combinational and has one output register stage. Each pointer is a plain 64-bit word that a register read returns. It is valid on every cycle and has no flow control, because no transfer takes place at the block's edge.

Top module: `tt_ptr_gen`

## Requirements
- R1: When tag-access bits 12:0 (the context) are all zero, both pointers are built from the context-zero base words and the context-zero shape word.
- R2: When any of tag-access bits 12:0 is set, both pointers are built from the nonzero-context words. Bits 63:13 of the tag-access word do not take part in this choice.
- R3: Pointer bits 63:13 carry the selected base word's bits 63:13. Index and split bits are OR-ed on top of them.
- R4: The index source is the tag-access word shifted right by 9 + 3 × P, where P is shape-word bits 2:0.
- R5: The shifted index keeps only bits 4 through 12 + S, where S is bits 3:0 of that class's base word.
- R6: Pointer bits 3:0 are always zero.
- R7: For class B only, if base bit 12 (the split flag) is set, pointer bit 13 + S is forced to one. Base bit 12 has no effect on the class A pointer.
- R8: Both classes use the same selected shape word, so identical base words give identical pointers when the split flag is clear.
- R9: The outputs are registered. They read zero while reset is asserted, and they show the pointer for the inputs present at a rising clock edge directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_access_i | input | 64 | Faulting virtual page (63:13) and context (12:0) |
| c0_base_a_i | input | 64 | Class A table base for context zero |
| c0_base_b_i | input | 64 | Class B table base for context zero |
| c0_shape_i | input | 64 | Shape word (page size in 2:0) for context zero |
| cx_base_a_i | input | 64 | Class A table base for nonzero contexts |
| cx_base_b_i | input | 64 | Class B table base for nonzero contexts |
| cx_shape_i | input | 64 | Shape word for nonzero contexts |
| ptr_a_o | output | 64 | Class A table pointer |
| ptr_b_o | output | 64 | Class B table pointer |

## Verification
The hardest case to reach is the class B split bit landing on a position the index mask also covers, or on a position where the base word already has a one. Only a chosen pairing of table size, page size and tag bits exposes a wrong bit position there. The stimulus fixes the size field and sets the split flag, then drives tag-access words of all ones and all zeros, so the forced bit stands out against both backgrounds. The context choice is checked with a context of bit 12 alone, and with a zero context under a nonzero page number. In both cases the unused register set holds values that differ from the selected set.

// File: rtl/tt_ptr_pkg.sv
package tt_ptr_pkg;
  localparam int VPN_LSB    = 13;
  localparam int IDX_LSB    = 4;
  localparam int SHIFT_BASE = 9;
  localparam int SHIFT_STEP = 3;
  localparam int PG_W       = 3;
  localparam int SZ_W       = 4;
  localparam int SPLIT_POS  = 12;
  localparam int NUM_CLASS  = 2;
endpackage

// File: rtl/tt_ctx_select.sv
module tt_ctx_select #(
  parameter int ADDR_W = 64,
  parameter int CTX_W  = 13
) (
  input  logic [ADDR_W-1:0] tag_i,
  input  logic [ADDR_W-1:0] c0_base_a_i,
  input  logic [ADDR_W-1:0] c0_base_b_i,
  input  logic [ADDR_W-1:0] c0_shape_i,
  input  logic [ADDR_W-1:0] cx_base_a_i,
  input  logic [ADDR_W-1:0] cx_base_b_i,
  input  logic [ADDR_W-1:0] cx_shape_i,
  output logic [ADDR_W-1:0] base_a_o,
  output logic [ADDR_W-1:0] base_b_o,
  output logic [ADDR_W-1:0] shape_o
);
  logic ctx_is_zero;
  logic unused_tag_hi;

  assign ctx_is_zero   = (tag_i[CTX_W-1:0] == '0);
  assign unused_tag_hi = ^tag_i[ADDR_W-1:CTX_W];

  always_comb begin
    if (ctx_is_zero) begin
      base_a_o = c0_base_a_i;
      base_b_o = c0_base_b_i;
      shape_o  = c0_shape_i;
    end else begin
      base_a_o = cx_base_a_i;
      base_b_o = cx_base_b_i;
      shape_o  = cx_shape_i;
    end
  end
endmodule

// File: rtl/tt_index_calc.sv
module tt_index_calc
  import tt_ptr_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] tag_i,
  input  logic [ADDR_W-1:0] shape_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic [ADDR_W-1:0] idx_o
);
  localparam int SH_W   = $clog2(ADDR_W) + 1;
  localparam int SZ_MAX = ADDR_W - 2 - SPLIT_POS;

  logic [SH_W-1:0]   shamt;
  logic [ADDR_W-1:0] shifted;
  logic [ADDR_W-1:0] keep;
  int                top_bit;
  logic              unused_shape;

  assign unused_shape = ^shape_i[ADDR_W-1:PG_W];
  assign shamt   = SH_W'(SHIFT_BASE) + SH_W'(SHIFT_STEP) * SH_W'(shape_i[PG_W-1:0]);
  assign shifted = tag_i >> shamt;

  always_comb begin
    if (int'(size_i) > SZ_MAX) top_bit = SPLIT_POS + SZ_MAX;
    else                       top_bit = SPLIT_POS + int'(size_i);
    for (int i = 0; i < ADDR_W; i++) begin
      keep[i] = (i >= IDX_LSB) && (i <= top_bit);
    end
  end

  assign idx_o = shifted & keep;

  always_comb begin
    a_idx_low_clear_r6: assert (idx_o[IDX_LSB-1:0] == '0);
  end
endmodule

// File: rtl/tt_ptr_assemble.sv
module tt_ptr_assemble
  import tt_ptr_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter bit HAS_SPLIT = 1'b0
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] idx_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int SZ_MAX = ADDR_W - 2 - SPLIT_POS;

  logic [ADDR_W-1:0] body;
  logic              unused_low;

  assign unused_low = ^base_i[SPLIT_POS:0];
  assign body = {base_i[ADDR_W-1:VPN_LSB], {VPN_LSB{1'b0}}} | idx_i;

  generate
    if (HAS_SPLIT) begin : g_split
      logic [ADDR_W-1:0] half_bit;
      int                pos;
      always_comb begin
        if (int'(base_i[SZ_W-1:0]) > SZ_MAX) pos = VPN_LSB + SZ_MAX;
        else                                 pos = VPN_LSB + int'(base_i[SZ_W-1:0]);
        half_bit = '0;
        if (base_i[SPLIT_POS]) half_bit[pos] = 1'b1;
      end
      assign ptr_o = body | half_bit;
    end else begin : g_plain
      assign ptr_o = body;
    end
  endgenerate
endmodule

// File: rtl/tt_ptr_gen.sv
module tt_ptr_gen
  import tt_ptr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CTX_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tag_access_i,
  input  logic [ADDR_W-1:0] c0_base_a_i,
  input  logic [ADDR_W-1:0] c0_base_b_i,
  input  logic [ADDR_W-1:0] c0_shape_i,
  input  logic [ADDR_W-1:0] cx_base_a_i,
  input  logic [ADDR_W-1:0] cx_base_b_i,
  input  logic [ADDR_W-1:0] cx_shape_i,
  output logic [ADDR_W-1:0] ptr_a_o,
  output logic [ADDR_W-1:0] ptr_b_o
);
  localparam int FREE_LSB = VPN_LSB + (2**SZ_W - 1) + 1;

  logic [ADDR_W-1:0] sel_base [NUM_CLASS];
  logic [ADDR_W-1:0] sel_shape;
  logic [ADDR_W-1:0] nxt_ptr  [NUM_CLASS];
  logic              past_ok;

  tt_ctx_select #(.ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_sel (
    .tag_i       (tag_access_i),
    .c0_base_a_i (c0_base_a_i),
    .c0_base_b_i (c0_base_b_i),
    .c0_shape_i  (c0_shape_i),
    .cx_base_a_i (cx_base_a_i),
    .cx_base_b_i (cx_base_b_i),
    .cx_shape_i  (cx_shape_i),
    .base_a_o    (sel_base[0]),
    .base_b_o    (sel_base[1]),
    .shape_o     (sel_shape)
  );

  generate
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
      logic [ADDR_W-1:0] idx;
      tt_index_calc #(.ADDR_W(ADDR_W)) u_idx (
        .tag_i   (tag_access_i),
        .shape_i (sel_shape),
        .size_i  (sel_base[c][SZ_W-1:0]),
        .idx_o   (idx)
      );
      tt_ptr_assemble #(.ADDR_W(ADDR_W), .HAS_SPLIT(c == 1)) u_asm (
        .base_i (sel_base[c]),
        .idx_i  (idx),
        .ptr_o  (nxt_ptr[c])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_a_o <= '0;
      ptr_b_o <= '0;
      past_ok <= 1'b0;
    end else begin
      ptr_a_o <= nxt_ptr[0];
      ptr_b_o <= nxt_ptr[1];
      past_ok <= 1'b1;
    end
  end

  p_ctx0_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(tag_access_i[CTX_W-1:0] == '0)) |->
      (ptr_a_o[ADDR_W-1:FREE_LSB] == $past(c0_base_a_i[ADDR_W-1:FREE_LSB])));

  p_ctxn_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(tag_access_i[CTX_W-1:0] != '0)) |->
      (ptr_b_o[ADDR_W-1:FREE_LSB] == $past(cx_base_b_i[ADDR_W-1:FREE_LSB])));

  p_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (ptr_a_o[IDX_LSB-1:0] == '0 && ptr_b_o[IDX_LSB-1:0] == '0));

  p_shared_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(sel_base[0] == sel_base[1] && !sel_base[1][SPLIT_POS])) |->
      (ptr_a_o == ptr_b_o));
endmodule

// File: tb/tb_tt_ptr_gen.sv
module tb_tt_ptr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tag, c0a, c0b, c0s, cxa, cxb, cxs;
  logic [63:0] pa, pb;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tt_ptr_gen dut (
    .clk(clk), .rst_n(rst_n), .tag_access_i(tag),
    .c0_base_a_i(c0a), .c0_base_b_i(c0b), .c0_shape_i(c0s),
    .cx_base_a_i(cxa), .cx_base_b_i(cxb), .cx_shape_i(cxs),
    .ptr_a_o(pa), .ptr_b_o(pb)
  );

  // vector: tag, base A, base B, shape
  localparam logic [3:0][63:0] VEC [8] = '{
    '{64'h0000_1234_5678_A000, 64'hFFFF_0000_0001_2003, 64'h0000_ABCD_0000_1005, 64'h1},
    '{64'h0000_0765_4321_E005, 64'h0000_0040_0000_0000, 64'h0000_0080_0000_0002, 64'h0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_000F, 64'h0000_0000_0000_100F, 64'h7},
    '{64'hDEAD_BEEF_CAFE_0000, 64'h1234_5678_0000_0000, 64'h1234_5678_0000_0000, 64'h3},
    '{64'h0000_0000_0000_1001, 64'h0000_1111_0000_6007, 64'h0000_2222_0000_7001, 64'h5},
    '{64'h8000_0000_0001_2000, 64'hAAAA_AAAA_AAAA_AAA0, 64'h5555_5555_5555_5550, 64'h2},
    '{64'h0F0F_0F0F_0F0F_E000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_1000, 64'h6},
    '{64'h0123_4567_89AB_CDEF, 64'h0000_0100_0000_0009, 64'h0000_0200_0000_1009, 64'h4}
  };

  function automatic logic [63:0] model(input logic [63:0] t, input logic [63:0] b,
                                        input logic [63:0] s, input bit split);
    logic [63:0] r, sh;
    int hi;
    r  = {b[63:13], 13'd0};
    sh = t >> (9 + 3 * int'(s[2:0]));
    hi = 12 + int'(b[3:0]);
    for (int i = 4; i <= hi; i++) r[i] = r[i] | sh[i];
    if (split && b[12]) r[13 + int'(b[3:0])] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] t, a0, b0, s0, ax, bx, sx);
    @(negedge clk);
    tag = t; c0a = a0; c0b = b0; c0s = s0; cxa = ax; cxb = bx; cxs = sx;
    @(negedge clk);
  endtask

  task automatic run_vec(input string req, input logic [63:0] t, a, b, s);
    logic [63:0] ja, jb, js;
    ja = ~a; jb = ~b; js = {61'd0, ~s[2:0]};
    if (t[12:0] == 13'd0) apply(t, a, b, s, ja, jb, js);
    else                  apply(t, ja, jb, js, a, b, s);
    check(req, pa, model(t, a, s, 1'b0));
    check(req, pb, model(t, b, s, 1'b1));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = '1; c0a = '1; c0b = '1; c0s = '1; cxa = '1; cxb = '1; cxs = '1;
    repeat (3) @(negedge clk);
    check("R9 reset A", pa, 64'd0);
    check("R9 reset B", pb, 64'd0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      run_vec("R1/R2/R3/R4/R5 table", VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);
    end

    // R2: only context bit 12 set selects nonzero set
    apply(64'h0000_0000_0000_1000, 64'hA000_0000_0000_0000, 64'd0, 64'd0,
          64'h5000_0000_0000_0000, 64'd0, 64'd0);
    check("R2 ctx bit12", pa, 64'h5000_0000_0000_0000);

    // R1: zero context under nonzero page picks context-zero set
    apply(64'hFFFF_FFFF_FFFF_E000, 64'hA000_0000_0000_0000, 64'd0, 64'd0,
          64'h5000_0000_0000_0000, 64'd0, 64'd0);
    check("R1 ctx zero", pa[63:32], 32'hA000_0000);

    // R4: page size 7 shifts by 30: tag bit 34 lands on pointer bit 4
    apply(64'h0000_0004_0000_0000, 64'd0, 64'd0, 64'd7, 64'd0, 64'd0, 64'd0);
    check("R4 shift 30", pa, 64'h10);

    // R5: size 0 keeps bits 4..12 only from an all-ones index
    apply(64'hFFFF_FFFF_FFFF_E000, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0);
    check("R5 mask size0", pa, 64'h1FF0);
    check("R6 low nibble", pa[3:0], 4'd0);

    // R5: size 15 keeps bits 4..27
    apply(64'hFFFF_FFFF_FFFF_E000, 64'hF, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0);
    check("R5 mask size15", pa, 64'h0FFF_FFF0);

    // R7: split with size 3 and zero tag sets only bit 16 on B; A ignores bit 12
    apply(64'h0, 64'h1003, 64'h1003, 64'd0, 64'd0, 64'd0, 64'd0);
    check("R7 split B", pb, 64'h0001_0000);
    check("R7 no split A", pa, 64'h0);

    // R8: identical bases without split give identical pointers
    apply(64'h0000_3C3C_3C3C_0000, 64'h0000_0000_0000_0006, 64'h0000_0000_0000_0006,
          64'd2, 64'd0, 64'd0, 64'd0);
    check("R8 shared shape", pb, pa);

    // R9: output follows the most recent edge
    apply(64'h0, 64'h8000_0000_0000_0000, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0);
    check("R9 update", pa, 64'h8000_0000_0000_0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule